// File: doc/BRIEF.md
# Run-Length Sample Record Expander

This block turns a stream of compressed capture records into a stream of 32-bit samples. Each record is four input bytes: three channel values and a repeat field. The expander emits the same sample as many times as the repeat field encodes, with the fourth channel always zero.

The output side is held to a sample budget that is loaded at the start of a run. When the budget runs out the run ends, even partway through a record, and any records still waiting at the input are left untouched. A run also ends when the producer signals the end of its stream and no record is partly received or still being expanded. The block keeps a count of the samples that have left it. That count and a done flag are the only results a run reports.

Bytes enter on an 8-bit valid/ready port. Samples leave on a 32-bit valid/ready port.

Top module: `rle_sample_expander`

## Requirements
- R1: A record is four bytes accepted in this order: channel A, then channel B, then channel C, then the repeat field. A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both high.
- R2: Each output sample holds channel A in bits 7:0, channel B in 15:8, channel C in 23:16, and zero in bits 31:24.
- R3: A record with repeat field value n produces n+1 identical samples, so a record produces 1 to 256 samples.
- R4: Accepting a sample lowers the remaining budget by one. A record that would go past the budget is cut short. `done` rises on the same edge that accepts the sample which uses up the budget.
- R5: Once `done` is high, `in_ready` and `out_valid` stay low, even if input bytes are still offered.
- R6: `written` counts the samples accepted on the output. A `start` pulse loads the budget from `limit`, clears `written` and clears `done`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R8: `in_ready` is low while a record is being expanded. The next record's first byte can only be accepted after the last repeat has left.
- R9: A `stream_end` pulse with no record pending raises `done` on the edge that samples it. With a record pending, `done` rises one cycle after that record's last sample is accepted.
- R10: A run started with `limit` equal to zero produces no samples. `done` rises on the edge after the start edge.
- R11: After reset, `done`, `in_ready`, `out_valid` and `written` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| limit | input | LIMIT_W | Output sample budget, loaded by `start` |
| stream_end | input | 1 | One-cycle pulse: the producer has no more records |
| in_data | input | CH_W | Input byte |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Expander can take an input byte |
| out_data | output | 4*CH_W | Expanded sample |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Consumer takes the sample |
| done | output | 1 | The run has ended |
| written | output | LIMIT_W | Samples accepted on the output in this run |

## Verification
Two events can fall in the same cycle.

The first is the acceptance of a record's repeat and the exhaustion of the budget. The bench provokes it with a budget that ends inside a long record, and with a budget equal to the exact sum of the records. In both cases `done` and the final value of `written` must appear on the edge that takes the last sample, and no further byte may be accepted.

The second is a `stream_end` pulse that arrives while a record is still being expanded under a slow consumer. Here `done` must wait until every repeat has been taken. A scoreboard of expected samples must be empty at that point.

// File: rtl/rle_sample_expander.sv
module rle_sample_expander #(
  parameter int CH_W    = 8,
  parameter int LIMIT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LIMIT_W-1:0]   limit,
  input  logic                 stream_end,
  input  logic [CH_W-1:0]      in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic [4*CH_W-1:0]    out_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 done,
  output logic [LIMIT_W-1:0]   written
);
  localparam int REP_W = CH_W + 1;

  logic               run, end_seen;
  logic [1:0]         slot;
  logic [CH_W-1:0]    ch_a, ch_b, ch_c;
  logic [REP_W-1:0]   reps;
  logic [LIMIT_W-1:0] budget;
  logic               in_fire, out_fire, rec_idle, finish;

  assign in_ready  = run && (reps == '0) && (budget != '0);
  assign out_valid = run && (reps != '0);
  assign out_data  = {{CH_W{1'b0}}, ch_c, ch_b, ch_a};
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign rec_idle  = (slot == 2'd0) && (reps == '0) && !in_fire;
  assign finish    = run && ((out_fire && budget == LIMIT_W'(1)) ||
                             (budget == '0) ||
                             ((end_seen || stream_end) && rec_idle));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; end_seen <= 1'b0; slot <= 2'd0;
      ch_a <= '0; ch_b <= '0; ch_c <= '0;
      reps <= '0; budget <= '0; written <= '0;
    end else if (start) begin
      run <= 1'b1; done <= 1'b0; end_seen <= 1'b0; slot <= 2'd0;
      reps <= '0; budget <= limit; written <= '0;
    end else begin
      if (stream_end && run) end_seen <= 1'b1;
      if (in_fire) begin
        slot <= slot + 2'd1;
        case (slot)
          2'd0: ch_a <= in_data;
          2'd1: ch_b <= in_data;
          2'd2: ch_c <= in_data;
          default: reps <= REP_W'(in_data) + REP_W'(1);
        endcase
      end
      if (out_fire) begin
        reps    <= reps - REP_W'(1);
        budget  <= budget - LIMIT_W'(1);
        written <= written + LIMIT_W'(1);
      end
      if (finish) begin
        run  <= 1'b0;
        done <= 1'b1;
        reps <= '0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=> out_valid && $stable(out_data));

  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !start |=> written == $past(written) + LIMIT_W'(1));

  p_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fire && !start |=> $stable(written));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !out_valid);

  p_budget_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> budget != '0);
endmodule

// File: tb/rle_sample_expander_bench.sv
module rle_sample_expander_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, stream_end = 1'b0;
  logic [15:0] limit = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, done;
  logic [31:0] out_data;
  logic [15:0] written;

  int checks = 0, errors = 0;
  int rem = 0, total_exp = 0, mode = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_sample_expander u_rle_sample_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .limit(limit),
    .stream_end(stream_end), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .done(done), .written(written));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: decides out_ready, pops scoreboard on each sample that will be taken
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0];
      default: out_ready = (cyc % 4 == 0);
    endcase
    if (prev_stall && !start) begin
      chk(out_valid, "R7 valid held", {31'b0, out_valid}, 1);
      chk(out_data == prev_data, "R7 data stable", out_data, prev_data);
    end
    if (out_valid) chk(!in_ready, "R8 in_ready low while expanding", {31'b0, in_ready}, 0);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected sample", out_data, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R1/R2 sample value", out_data, e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  end

  task automatic begin_run(input int lim);
    limit = 16'(lim); rem = lim; total_exp = 0; exp_q.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1: bytes in order A, B, C, repeat; called and returns at a falling edge
  task automatic send_rec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] r);
    logic [7:0] bytes [4];
    bytes[0] = a; bytes[1] = b; bytes[2] = c; bytes[3] = r;
    for (int i = 0; i < 4; i++) begin
      in_data = bytes[i]; in_valid = 1'b1;
      while (!in_ready && !done) @(negedge clk);
      if (done) begin in_valid = 1'b0; return; end
      if (i == 3) begin
        int n;
        n = int'(r) + 1;
        if (n > rem) n = rem;
        for (int k = 0; k < n; k++) exp_q.push_back({8'h00, c, b, a});
        rem -= n; total_exp += n;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!done && !in_ready && !out_valid && written == 0, "R11 reset state",
        {done, in_ready, out_valid, 13'b0, written}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: budget ends inside a long record
    mode = 0;
    begin_run(100);
    send_rec(8'h11, 8'h22, 8'h33, 8'd0);
    send_rec(8'h44, 8'h55, 8'h66, 8'd3);
    send_rec(8'h77, 8'h88, 8'h99, 8'd255);
    wait_done();
    chk(written == 100, "R4 truncated total", written, 100);
    chk(exp_q.size() == 0, "R3 all samples seen", exp_q.size(), 0);
    // R5: further input ignored
    in_data = 8'h5A; in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!in_ready && !out_valid, "R5 quiet after done", {in_ready, out_valid}, 0);
    end
    in_valid = 1'b0;
    chk(written == 100, "R5 written unchanged", written, 100);

    // R9: stream_end with nothing pending, random consumer
    mode = 1;
    begin_run(1000);
    send_rec(8'h01, 8'h02, 8'h03, 8'd7);
    send_rec(8'hFF, 8'h00, 8'hA5, 8'd0);
    send_rec(8'h10, 8'h20, 8'h30, 8'd40);
    send_rec(8'hC3, 8'h3C, 8'h81, 8'd1);
    drain();
    @(negedge clk);
    stream_end = 1'b1;
    @(negedge clk);
    stream_end = 1'b0;
    chk(done, "R9 done on edge sampling stream_end", {31'b0, done}, 1);
    chk(written == 16'(total_exp), "R6 written total", written, total_exp);

    // R9: stream_end while a record is still expanding, slow consumer
    mode = 2;
    begin_run(1000);
    send_rec(8'hDE, 8'hAD, 8'hBE, 8'd5);
    stream_end = 1'b1;
    @(negedge clk);
    stream_end = 1'b0;
    chk(!done, "R9 done waits for pending record", {31'b0, done}, 0);
    wait_done();
    chk(written == 6, "R9 all repeats before done", written, 6);
    chk(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 0);

    // R10: zero budget
    mode = 0;
    begin_run(0);
    chk(!done && !in_ready, "R10 first cycle", {done, in_ready}, 0);
    @(negedge clk);
    chk(done, "R10 done after start", {31'b0, done}, 1);
    chk(written == 0, "R10 no samples", written, 0);

    // R4: budget equals exact sum of records
    mode = 1;
    begin_run(10);
    send_rec(8'h0A, 8'h0B, 8'h0C, 8'd3);
    send_rec(8'h1A, 8'h1B, 8'h1C, 8'd5);
    wait_done();
    chk(written == 10, "R4 exact budget", written, 10);
    chk(!in_ready, "R5 no intake at exact end", {31'b0, in_ready}, 0);

    // R6: start clears written and done
    mode = 0;
    begin_run(7);
    chk(written == 0 && !done, "R6 start clears", {done, 15'b0, written}, 0);
    send_rec(8'h21, 8'h43, 8'h65, 8'd2);
    drain();
    stream_end = 1'b1;
    @(negedge clk);
    stream_end = 1'b0;
    chk(done && written == 3, "R6 count after restart", {done, 15'b0, written}, {1'b1, 15'b0, 16'd3});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule